// File: doc/BRIEF.md
# Operand Input Register Stage with Cascade Tap

This block conditions one operand on its way into an arithmetic slice. A static parameter decides whether the operand comes from the block's own data port or from the cascade input that the upstream slice drives. The chosen operand then passes through zero, one or two registers before it reaches the datapath output.

A second output feeds the next slice in a chain. It is taken after a number of registers that is set on its own. That number must equal the main depth or be one less. A main depth of 2 with a tap of 1 lets a chain of slices stagger their operands by one cycle each. Depth 0 needs tap 0, depth 1 needs tap 1, and depth 2 takes tap 1 or tap 2. Any other pair stops elaboration with an error.

Each register has its own clock enable. A parameter picks the reset style: a synchronous reset input, or one common asynchronous reset that clears every register. A second parameter inverts the reset polarity so the reset acts active-low.

Top module: `operand_stage_pipe`

## Requirements
- R1: With `SEL_CASCADE` = 0 the stage carries `din`. With `SEL_CASCADE` = 1 it carries `cin`. The input that is not selected has no effect on either output.
- R2: With `DEPTH` = 0, `dout` and `cout` both equal the selected input in the same cycle, with no register between them.
- R3: With `DEPTH` = 1, a single register drives both `dout` and `cout`. It loads the selected input on a clock edge where `ce2` is 1, and `ce1` has no effect on it.
- R4: With `DEPTH` = 2, the first register loads the selected input when `ce1` is 1. The second register loads the first register when `ce2` is 1. `dout` is the second register.
- R5: With `DEPTH` = 2, `cout` is the first register when `TAP` = 1 and the second register when `TAP` = 2.
- R6: On a clock edge where a register's enable is 0 and no reset is active, that register keeps its value.
- R7: With `ASYNC_RST` = 0, an active `rst` clears every register to zero on the next clock edge, whatever the enables are. `arst` has no effect in this mode.
- R8: With `ASYNC_RST` = 1, an active `arst` clears every register at once, without waiting for a clock edge, and holds them at zero while it stays active. `rst` has no effect in this mode.
- R9: With `RST_INV` = 1, the reset input in use is active when it is 0 and inactive when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, used when `ASYNC_RST` = 0 |
| arst | input | 1 | Common asynchronous reset, used when `ASYNC_RST` = 1 |
| ce1 | input | 1 | Enable for the first register when `DEPTH` = 2 |
| ce2 | input | 1 | Enable for the last register when `DEPTH` is 1 or 2 |
| din | input | WIDTH | Direct operand input |
| cin | input | WIDTH | Cascade operand input from the upstream slice |
| dout | output | WIDTH | Operand to the datapath |
| cout | output | WIDTH | Operand to the downstream slice |

## Verification
The bench runs four configurations side by side:
- depth 2, tap 1, direct input, synchronous active-high reset;
- depth 2, tap 2, cascade input, synchronous active-low reset;
- depth 1, asynchronous reset;
- depth 0.

**Tap and enables.** The bench drives the two enables apart. A design that takes the tap after the wrong register, or that swaps `ce1` and `ce2`, then shows a `cout` that is a cycle early or late, or a stale operand.

**Reset.** Resets are asserted while the enables are high, so a design that lets an enable win over reset keeps a non-zero value. The asynchronous reset is checked between clock edges, so a design with a synchronous clear shows the old value there. The reset input that the configuration does not use is toggled, so a design that honours it clears when it should not. The active-low instance shows whether the polarity inversion is applied.

**Source select.** `din` and `cin` always carry different values, so a design that picks the wrong source gives a wrong operand at once.

// File: rtl/operand_stage_pipe.sv
module operand_stage_pipe #(
  parameter int WIDTH       = 34,
  parameter int DEPTH       = 1,
  parameter int TAP         = 1,
  parameter bit SEL_CASCADE = 1'b0,
  parameter bit ASYNC_RST   = 1'b0,
  parameter bit RST_INV     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arst,
  input  logic             ce1,
  input  logic             ce2,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cin,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] cout
);
  localparam bit LEGAL = (DEPTH == 0 && TAP == 0) ||
                         (DEPTH == 1 && TAP == 1) ||
                         (DEPTH == 2 && (TAP == 1 || TAP == 2));

  if (!LEGAL) begin : g_illegal
    $error("operand_stage_pipe: illegal DEPTH/TAP pair");
  end

  logic [WIDTH-1:0] sel_in, st1, st2, d2;
  logic rst_s, rst_a;

  assign sel_in = SEL_CASCADE ? cin : din;
  assign rst_s  = !ASYNC_RST && (rst ^ RST_INV);
  assign rst_a  = ASYNC_RST && (arst ^ RST_INV);

  if (DEPTH == 2) begin : g_first
    always_ff @(posedge clk or posedge rst_a)
      if (rst_a)      st1 <= '0;
      else if (rst_s) st1 <= '0;
      else if (ce1)   st1 <= sel_in;
    assign d2 = st1;
  end else begin : g_no_first
    assign st1 = '0;
    assign d2  = sel_in;
  end

  if (DEPTH >= 1) begin : g_last
    always_ff @(posedge clk or posedge rst_a)
      if (rst_a)      st2 <= '0;
      else if (rst_s) st2 <= '0;
      else if (ce2)   st2 <= d2;
  end else begin : g_bypass
    assign st2 = sel_in;
  end

  assign dout = st2;
  assign cout = (DEPTH == 2 && TAP == 1) ? st1 : st2;
endmodule

module operand_stage_pipe_chk #(
  parameter int WIDTH       = 34,
  parameter int DEPTH       = 1,
  parameter int TAP         = 1,
  parameter bit SEL_CASCADE = 1'b0,
  parameter bit ASYNC_RST   = 1'b0,
  parameter bit RST_INV     = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             arst,
  input logic             ce1,
  input logic             ce2,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] cin,
  input logic [WIDTH-1:0] dout,
  input logic [WIDTH-1:0] cout
);
  logic [WIDTH-1:0] chk_sel;
  logic chk_rs, chk_ra;
  assign chk_sel = SEL_CASCADE ? cin : din;
  assign chk_rs  = !ASYNC_RST && (rst ^ RST_INV);
  assign chk_ra  = ASYNC_RST && (arst ^ RST_INV);

  assert_comb_copy_R2: assert property (@(posedge clk)
    (DEPTH == 0) |-> (dout == chk_sel && cout == chk_sel));

  assert_single_load_R3: assert property (@(posedge clk) disable iff (chk_ra)
    (DEPTH == 1 && !chk_rs && ce2) |=> (dout == $past(chk_sel)));

  assert_tap_first_R5: assert property (@(posedge clk) disable iff (chk_ra)
    (DEPTH == 2 && TAP == 1 && !chk_rs && ce1) |=> (cout == $past(chk_sel)));

  assert_hold_last_R6: assert property (@(posedge clk) disable iff (chk_ra)
    (DEPTH > 0 && !chk_rs && !ce2) |=> $stable(dout));

  assert_sync_clear_R7: assert property (@(posedge clk) disable iff (chk_ra)
    (DEPTH > 0 && chk_rs) |=> (dout == '0 && cout == '0));

  assert_async_clear_R8: assert property (@(posedge clk)
    (DEPTH > 0 && chk_ra) |-> (dout == '0 && cout == '0));
endmodule

bind operand_stage_pipe operand_stage_pipe_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .TAP(TAP), .SEL_CASCADE(SEL_CASCADE),
  .ASYNC_RST(ASYNC_RST), .RST_INV(RST_INV)
) u_chk (
  .clk(clk), .rst(rst), .arst(arst), .ce1(ce1), .ce2(ce2),
  .din(din), .cin(cin), .dout(dout), .cout(cout)
);

// File: tb/tb_operand_stage_pipe.sv
module tb_operand_stage_pipe;
  localparam int W = 16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_h, rst_n, arst, ce1, ce2;
  logic [W-1:0] din, cin;
  logic [W-1:0] a_do, a_co, b_do, b_co, c_do, c_co, d_do, d_co;
  logic [W-1:0] ma1, ma2, mb1, mb2, mc2;
  int checks = 0, fails = 0;
  bit done = 0;

  operand_stage_pipe #(.WIDTH(W), .DEPTH(2), .TAP(1), .SEL_CASCADE(0), .ASYNC_RST(0), .RST_INV(0))
    dut (.clk(clk), .rst(rst_h), .arst(arst), .ce1(ce1), .ce2(ce2), .din(din), .cin(cin), .dout(a_do), .cout(a_co));
  operand_stage_pipe #(.WIDTH(W), .DEPTH(2), .TAP(2), .SEL_CASCADE(1), .ASYNC_RST(0), .RST_INV(1))
    u_b (.clk(clk), .rst(rst_n), .arst(arst), .ce1(ce1), .ce2(ce2), .din(din), .cin(cin), .dout(b_do), .cout(b_co));
  operand_stage_pipe #(.WIDTH(W), .DEPTH(1), .TAP(1), .SEL_CASCADE(0), .ASYNC_RST(1), .RST_INV(0))
    u_c (.clk(clk), .rst(rst_h), .arst(arst), .ce1(ce1), .ce2(ce2), .din(din), .cin(cin), .dout(c_do), .cout(c_co));
  operand_stage_pipe #(.WIDTH(W), .DEPTH(0), .TAP(0), .SEL_CASCADE(1), .ASYNC_RST(0), .RST_INV(0))
    u_d (.clk(clk), .rst(rst_h), .arst(arst), .ce1(ce1), .ce2(ce2), .din(din), .cin(cin), .dout(d_do), .cout(d_co));

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R4"}, "dut dout", a_do, ma2);
    chk({tag, " R5"}, "dut cout tap1", a_co, ma1);
    chk({tag, " R9"}, "b dout", b_do, mb2);
    chk({tag, " R5"}, "b cout tap2", b_co, mb2);
    chk({tag, " R3"}, "c dout", c_do, mc2);
    chk({tag, " R3"}, "c cout", c_co, mc2);
    chk({tag, " R2"}, "d dout", d_do, cin);
    chk({tag, " R1"}, "d cout", d_co, cin);
  endtask

  function automatic logic [W-1:0] rnd_diff(logic [W-1:0] other);
    logic [W-1:0] v = W'($urandom);
    if (v == other) v = ~other;
    return v;
  endfunction

  task automatic step(string tag);
    @(posedge clk);
    if (rst_h) begin ma1 = '0; ma2 = '0; end
    else begin if (ce2) ma2 = ma1; if (ce1) ma1 = din; end
    if (!rst_n) begin mb1 = '0; mb2 = '0; end
    else begin if (ce2) mb2 = mb1; if (ce1) mb1 = cin; end
    if (arst) mc2 = '0; else if (ce2) mc2 = din;
    @(negedge clk); #0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_h = 1; rst_n = 0; arst = 1; ce1 = 1; ce2 = 1;
    din = 16'h1111; cin = 16'h2222;
    ma1 = 0; ma2 = 0; mb1 = 0; mb2 = 0; mc2 = 0;
    step("reset R7"); step("reset R7");
    rst_h = 0; rst_n = 1; arst = 0;

    din = 16'hA5A5; cin = 16'h5A5A; step("load R1");
    din = 16'h0F0F; cin = 16'hF0F0; step("load R4");

    ce1 = 0; ce2 = 0; din = 16'h1234; cin = 16'h4321;
    step("hold R6"); step("hold R6");
    ce1 = 1; ce2 = 0; din = 16'h7777; cin = 16'h8888; step("split enable R5");
    ce1 = 0; ce2 = 1; step("split enable R4");

    ce1 = 1; ce2 = 1; rst_h = 1; rst_n = 0; din = 16'hFFFF; cin = 16'hEEEE;
    step("sync reset priority R7");
    rst_h = 0; rst_n = 1; step("after reset R7"); step("after reset R7");

    rst_n = 0; step("active-low reset R9");
    rst_n = 1; step("active-low release R9");

    rst_h = 1; rst_n = 1; arst = 0; step("sync rst ignored by async R8");
    rst_h = 0;
    arst = 1; #1; mc2 = '0; ma1 = ma1;
    chk("R8", "c async clear", c_do, 16'h0000);
    chk("R7", "dut ignores arst", a_do, ma2);
    step("async held R8");
    arst = 0; step("async release R8");

    for (int i = 0; i < 400; i++) begin
      ce1 = $urandom_range(0, 3) != 0;
      ce2 = $urandom_range(0, 3) != 0;
      din = W'($urandom);
      cin = rnd_diff(din);
      rst_h = $urandom_range(0, 19) == 0;
      rst_n = !($urandom_range(0, 19) == 0);
      arst = $urandom_range(0, 19) == 0;
      if (arst) begin #1; mc2 = '0; chk("R8", "c async random", c_do, 16'h0000); end
      step("random R1");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule